// File: doc/BRIEF.md
# Saturating Wide-Dividend Integer Divider

This block divides a double-width dividend by a single-width divisor over many clock cycles. The dividend's upper word comes from a separate high-word input, and the first operand supplies the lower word. The divisor is either the second operand or a short sign-extended immediate. An unsigned mode and a signed mode are both supported. The quotient is returned in a double-width result, and any quotient that does not fit in a single word is clamped to a fixed saturation value instead of wrapping.

A caller raises `start_i` for one cycle while the block is idle. The block then reports `busy_o` until a one-cycle `done_o` pulse. That pulse carries the result, an overflow flag for condition codes (set when saturation occurred), a carry flag that is always cleared, and a division-by-zero trap indication. A zero divisor raises the trap and leaves the previously written result untouched. Internally, a restoring radix-2 engine retires a parameterisable number of quotient bits per clock. Signed division works on magnitudes and then applies the sign, which truncates the quotient toward zero.

Top module: `sat_divider`

## Requirements
- R1: The dividend is `{hi_word_i, opa_i}` (high word in bits 63:32, first operand in bits 31:0), sampled in the cycle the start is accepted.
- R2: With `imm_sel_i`=1 the divisor is `imm_i` sign-extended from 13 to 32 bits; with `imm_sel_i`=0 it is `opb_i`.
- R3: In unsigned mode (`signed_i`=0) a quotient below 2^32 is returned zero-extended in `result_o`, with `ovf_o`=0.
- R4: In unsigned mode a quotient of 2^32 or more gives `result_o`=0x00000000FFFFFFFF and `ovf_o`=1.
- R5: In signed mode (`signed_i`=1) the quotient truncates toward zero and is returned sign-extended to 64 bits, with `ovf_o`=0 while it lies within -2^31..2^31-1 (including exactly -2^31).
- R6: In signed mode a quotient above 2^31-1 gives `result_o`=0x000000007FFFFFFF and `ovf_o`=1.
- R7: In signed mode a quotient below -2^31 gives `result_o`=0xFFFFFFFF80000000 and `ovf_o`=1.
- R8: A zero divisor gives `dbz_o`=1 together with `done_o`, leaves `result_o` at its previous value and reads `ovf_o`=0; any nonzero divisor gives `dbz_o`=0.
- R9: `carry_o` reads 0 at every completion.
- R10: A start while idle makes `busy_o` high from the next cycle. `done_o` is a one-cycle pulse 65 clock edges after the accepting edge (for STEPS_PER_CLK=1), or 1 edge after it for a zero divisor. `busy_o` is low in the done cycle, so a new start may be accepted in that cycle.
- R11: A start raised while `busy_o` is high is ignored: it produces no extra completion and does not alter the running division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request a division (taken only when idle) |
| signed_i | input | 1 | 1 = signed mode, 0 = unsigned mode |
| imm_sel_i | input | 1 | 1 = divisor from immediate, 0 = from `opb_i` |
| hi_word_i | input | 32 | Upper word of the dividend |
| opa_i | input | 32 | Lower word of the dividend |
| opb_i | input | 32 | Register divisor |
| imm_i | input | 13 | Immediate divisor, sign-extended |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Saturated quotient |
| ovf_o | output | 1 | Saturation occurred |
| carry_o | output | 1 | Carry flag, always cleared |
| dbz_o | output | 1 | Division-by-zero trap |

## Verification
The completion of one division and the acceptance of the next can fall in the same cycle. The bench therefore launches every new request exactly in the cycle where `done_o` is seen, and the scoreboard judges that both results come back in order with correct values and latency. A request that lands while busy can also coincide with the final working cycle. The bench provokes this by pulsing start with different operands mid-run and in the last busy cycle. It judges the outcome by the absence of any extra completion and by the unchanged result of the running division.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_operand_prep.sv
module sdiv_operand_prep #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 13
) (
  input  logic                  signed_i,
  input  logic                  imm_sel_i,
  input  logic [DATA_W-1:0]     hi_word_i,
  input  logic [DATA_W-1:0]     opa_i,
  input  logic [DATA_W-1:0]     opb_i,
  input  logic [IMM_W-1:0]      imm_i,
  output logic [2*DATA_W-1:0]   dvd_mag_o,
  output logic [DATA_W-1:0]     dvs_mag_o,
  output logic                  neg_o,
  output logic                  zero_o
);
  localparam int DVD_W = 2 * DATA_W;
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DVD_W-1:0]  dvd;
  logic [DATA_W-1:0] dvs;
  logic              dvd_neg;
  logic              dvs_neg;

  always_comb begin
    dvd = {hi_word_i, opa_i};
    if (imm_sel_i) dvs = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    else           dvs = opb_i;
    dvd_neg   = signed_i & dvd[DVD_W-1];
    dvs_neg   = signed_i & dvs[DATA_W-1];
    dvd_mag_o = dvd_neg ? (~dvd + DVD_W'(1)) : dvd;
    dvs_mag_o = dvs_neg ? (~dvs + DATA_W'(1)) : dvs;
    neg_o     = dvd_neg ^ dvs_neg;
    zero_o    = (dvs == '0);
  end
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int DVD_W = 64,
  parameter int DVS_W = 32,
  parameter int STEPS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic [DVD_W-1:0] quot_o
);
  logic [DVS_W-1:0] rem_q, rem_d;
  logic [DVS_W-1:0] dvs_q, dvs_d;
  logic [DVD_W-1:0] quo_q, quo_d;

  logic [DVS_W-1:0] rem_s [0:STEPS];
  logic [DVD_W-1:0] quo_s [0:STEPS];

  assign rem_s[0] = rem_q;
  assign quo_s[0] = quo_q;

  // One restoring step per stage; STEPS stages are chained per clock.
  for (genvar g = 0; g < STEPS; g++) begin : g_stage
    logic [DVS_W:0] shifted;
    logic [DVS_W:0] trial;
    assign shifted      = {rem_s[g], quo_s[g][DVD_W-1]};
    assign trial        = shifted - {1'b0, dvs_q};
    assign rem_s[g+1]   = trial[DVS_W] ? shifted[DVS_W-1:0] : trial[DVS_W-1:0];
    assign quo_s[g+1]   = {quo_s[g][DVD_W-2:0], ~trial[DVS_W]};
  end

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    dvs_d = dvs_q;
    if (load_i) begin
      rem_d = '0;
      quo_d = dividend_i;
      dvs_d = divisor_i;
    end else if (step_i) begin
      rem_d = rem_s[STEPS];
      quo_d = quo_s[STEPS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
    end
  end

  assign quot_o = quo_q;

  // Partial remainder stays below the divisor for every quotient bit (R3, R5).
  p_rem_below_dvs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/sdiv_saturate.sv
module sdiv_saturate #(
  parameter int DATA_W = 32
) (
  input  logic [2*DATA_W-1:0] quot_mag_i,
  input  logic                signed_i,
  input  logic                neg_i,
  output logic [2*DATA_W-1:0] result_o,
  output logic                sat_o
);
  localparam int RES_W = 2 * DATA_W;
  localparam logic [RES_W-1:0] U_MAX = {{DATA_W{1'b0}}, {DATA_W{1'b1}}};
  localparam logic [RES_W-1:0] P_MAX = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic [RES_W-1:0] N_MIN = {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic [RES_W-1:0] N_LIM = RES_W'(1) << (DATA_W - 1);

  always_comb begin
    result_o = quot_mag_i;
    sat_o    = 1'b0;
    if (!signed_i) begin
      if (quot_mag_i[RES_W-1:DATA_W] != '0) begin
        result_o = U_MAX;
        sat_o    = 1'b1;
      end
    end else if (neg_i) begin
      if (quot_mag_i > N_LIM) begin
        result_o = N_MIN;
        sat_o    = 1'b1;
      end else begin
        result_o = ~quot_mag_i + RES_W'(1);
      end
    end else if (quot_mag_i > P_MAX) begin
      result_o = P_MAX;
      sat_o    = 1'b1;
    end
  end
endmodule

// File: rtl/sat_divider.sv
module sat_divider #(
  parameter int DATA_W        = 32,
  parameter int IMM_W         = 13,
  parameter int STEPS_PER_CLK = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                signed_i,
  input  logic                imm_sel_i,
  input  logic [DATA_W-1:0]   hi_word_i,
  input  logic [DATA_W-1:0]   opa_i,
  input  logic [DATA_W-1:0]   opb_i,
  input  logic [IMM_W-1:0]    imm_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [2*DATA_W-1:0] result_o,
  output logic                ovf_o,
  output logic                carry_o,
  output logic                dbz_o
);
  import sdiv_pkg::*;

  localparam int DVD_W = 2 * DATA_W;
  localparam int ITER  = DVD_W / STEPS_PER_CLK;
  localparam int CNT_W = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ITER - 1);
  localparam logic [DVD_W-1:0] P_MAX = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic [DVD_W-1:0] N_MIN = {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic [DVD_W-1:0] U_MAX = {{DATA_W{1'b0}}, {DATA_W{1'b1}}};

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // Operand conditioning
  logic [DVD_W-1:0]  dvd_mag;
  logic [DATA_W-1:0] dvs_mag;
  logic              op_neg;
  logic              op_zero;

  sdiv_operand_prep #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_prep (
    .signed_i  (signed_i),
    .imm_sel_i (imm_sel_i),
    .hi_word_i (hi_word_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .imm_i     (imm_i),
    .dvd_mag_o (dvd_mag),
    .dvs_mag_o (dvs_mag),
    .neg_o     (op_neg),
    .zero_o    (op_zero)
  );

  // Control state
  sdiv_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sgn_q, sgn_d;
  logic             neg_q, neg_d;
  logic             zero_q, zero_d;
  logic             accept;
  logic             core_load;
  logic             core_step;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign core_load = accept && !op_zero;
  assign core_step = (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sgn_d   = sgn_q;
    neg_d   = neg_q;
    zero_d  = zero_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          sgn_d   = signed_i;
          neg_d   = op_neg;
          zero_d  = op_zero;
          cnt_d   = '0;
          state_d = op_zero ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_LAST) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sgn_q   <= 1'b0;
      neg_q   <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sgn_q   <= sgn_d;
      neg_q   <= neg_d;
      zero_q  <= zero_d;
    end
  end

  // Iterative engine
  logic [DVD_W-1:0] quot_mag;

  sdiv_core #(.DVD_W(DVD_W), .DVS_W(DATA_W), .STEPS(STEPS_PER_CLK)) u_core (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .load_i     (core_load),
    .step_i     (core_step),
    .dividend_i (dvd_mag),
    .divisor_i  (dvs_mag),
    .quot_o     (quot_mag)
  );

  // Sign fix-up and clamping
  logic [DVD_W-1:0] fixed_res;
  logic             fixed_sat;

  sdiv_saturate #(.DATA_W(DATA_W)) u_sat (
    .quot_mag_i (quot_mag),
    .signed_i   (sgn_q),
    .neg_i      (neg_q),
    .result_o   (fixed_res),
    .sat_o      (fixed_sat)
  );

  // Output registers, written only in the finishing cycle
  logic             fin_en;
  logic             done_d, done_q;
  logic [DVD_W-1:0] res_d, res_q;
  logic             ovf_d, ovf_q;
  logic             dbz_d, dbz_q;

  assign fin_en = (state_q == ST_FIN);

  always_comb begin
    done_d = fin_en;
    res_d  = res_q;
    ovf_d  = ovf_q;
    dbz_d  = dbz_q;
    if (fin_en) begin
      dbz_d = zero_q;
      if (zero_q) begin
        ovf_d = 1'b0;
      end else begin
        res_d = fixed_res;
        ovf_d = fixed_sat;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      done_q <= 1'b0;
      res_q  <= '0;
      ovf_q  <= 1'b0;
      dbz_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      res_q  <= res_d;
      ovf_q  <= ovf_d;
      dbz_q  <= dbz_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = res_q;
  assign ovf_o    = ovf_q;
  assign dbz_o    = dbz_q;
  assign carry_o  = 1'b0;  // division never produces a carry (R9)

  // Assertions
  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!busy_o && start_i) |=> busy_o);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    done_o |=> !done_o);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    done_o |-> !busy_o);

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n_int)
    busy_o |=> ($stable(sgn_q) && $stable(neg_q) && $stable(zero_q)));

  p_dbz_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (done_o && dbz_o) |-> ($stable(result_o) && !ovf_o));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (done_o && !dbz_o && ovf_o && !sgn_q) |-> (result_o == U_MAX));

  p_sgn_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (done_o && !dbz_o && ovf_o && sgn_q) |-> ((result_o == P_MAX) || (result_o == N_MIN)));
endmodule

// File: tb/test_sat_divider.sv
module test_sat_divider;
  localparam int ITER    = 64;
  localparam int LAT_RUN = ITER + 1;

  typedef struct {
    logic [63:0] res;
    logic        ovf;
    logic        dbz;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        sgn;
  logic        isel;
  logic [31:0] hi;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [12:0] imm;
  logic        busy;
  logic        done;
  logic [63:0] result;
  logic        ovf;
  logic        carry;
  logic        dbz;

  int checks = 0;
  int fails  = 0;
  exp_t sb_q[$];
  logic [63:0] model_last = '0;

  sat_divider i_sat_divider (
    .clk(clk), .rst_n(rst_n), .start_i(start), .signed_i(sgn), .imm_sel_i(isel),
    .hi_word_i(hi), .opa_i(opa), .opb_i(opb), .imm_i(imm),
    .busy_o(busy), .done_o(done), .result_o(result), .ovf_o(ovf),
    .carry_o(carry), .dbz_o(dbz)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%016h expected 0x%016h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Reference model from the requirements
  function automatic exp_t model(input logic [31:0] y, input logic [31:0] a, input logic [31:0] b,
                                 input logic [12:0] im, input logic is, input logic sg, input string tag);
    exp_t e;
    logic [63:0] dd;
    logic [31:0] dv;
    logic [63:0] uq;
    logic signed [127:0] sdd, sdv, sq;
    dd = {y, a};
    dv = is ? {{19{im[12]}}, im} : b;
    e.tag = tag;
    e.dbz = 1'b0;
    e.ovf = 1'b0;
    if (dv == 32'd0) begin
      e.dbz = 1'b1;
      e.res = model_last;
    end else if (!sg) begin
      uq = dd / {32'd0, dv};
      if (uq > 64'h0000_0000_FFFF_FFFF) begin
        e.res = 64'h0000_0000_FFFF_FFFF;
        e.ovf = 1'b1;
      end else e.res = uq;
    end else begin
      sdd = {{64{dd[63]}}, dd};
      sdv = {{96{dv[31]}}, dv};
      sq  = sdd / sdv;
      if (sq > 128'sd2147483647) begin
        e.res = 64'h0000_0000_7FFF_FFFF;
        e.ovf = 1'b1;
      end else if (sq < -128'sd2147483648) begin
        e.res = 64'hFFFF_FFFF_8000_0000;
        e.ovf = 1'b1;
      end else e.res = sq[63:0];
    end
    if (!e.dbz) model_last = e.res;
    return e;
  endfunction

  // Driver: called at a negedge; returns at the negedge where done is seen.
  task automatic issue(input logic [31:0] y, input logic [31:0] a, input logic [31:0] b,
                       input logic [12:0] im, input logic is, input logic sg,
                       input bit poke, input string tag);
    exp_t e;
    int k;
    int lat;
    e = model(y, a, b, im, is, sg, tag);
    sb_q.push_back(e);
    lat = e.dbz ? 1 : LAT_RUN;
    hi = y; opa = a; opb = b; imm = im; isel = is; sgn = sg; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    k = 0;
    chk(busy == 1'b1, {"R10 busy after accept ", tag}, 64'(busy), 64'd1);
    while (!done && k < 300) begin
      if (poke && (k == 10 || k == ITER)) begin
        // R11: start while busy with different operands
        start = 1'b1; hi = ~y; opa = ~a; opb = 32'd3; isel = 1'b0; sgn = ~sg;
      end else begin
        start = 1'b0; hi = 32'hA5A5_A5A5; opa = 32'h5A5A_5A5A;
      end
      @(posedge clk);
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk(done && k == lat, {"R10 done latency ", tag}, 64'(k), 64'(lat));
  endtask

  // Monitor: scoreboard comparison on each completion
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R11 unexpected completion", result, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(result == e.res, {e.tag, " result"}, result, e.res);
        chk(ovf == e.ovf, {e.tag, " ovf"}, 64'(ovf), 64'(e.ovf));
        chk(dbz == e.dbz, {"R8 dbz ", e.tag}, 64'(dbz), 64'(e.dbz));
        chk(carry == 1'b0, {"R9 carry ", e.tag}, 64'(carry), 64'd0);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lcg;
    rst_n = 1'b0; start = 1'b0; sgn = 1'b0; isel = 1'b0;
    hi = '0; opa = '0; opb = '0; imm = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0,   "R10 reset busy", 64'(busy), 64'd0);
    chk(done == 1'b0,   "R10 reset done", 64'(done), 64'd0);
    chk(result == '0,   "R3 reset result", result, 64'd0);
    chk(ovf == 1'b0,    "R4 reset ovf", 64'(ovf), 64'd0);
    chk(dbz == 1'b0,    "R8 reset dbz", 64'(dbz), 64'd0);

    issue(32'h0, 32'd100, 32'd7, 13'h0, 1'b0, 1'b0, 1'b0, "R3 100/7");
    issue(32'h0, 32'd100, 32'hFFFF_FFFF, 13'd5, 1'b1, 1'b0, 1'b0, "R2 imm 100/5");
    issue(32'h1, 32'h0, 32'd2, 13'h0, 1'b0, 1'b0, 1'b0, "R1 hi word 2^32/2");
    issue(32'h5, 32'h0, 32'd3, 13'h0, 1'b0, 1'b0, 1'b0, "R4 unsigned clamp");
    issue(32'h2, 32'h0, 32'd2, 13'h0, 1'b0, 1'b0, 1'b0, "R4 quotient 2^32");
    issue(32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 13'h0, 1'b0, 1'b0, 1'b0, "R3 max fit");
    issue(32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2, 13'h0, 1'b0, 1'b1, 1'b0, "R5 -7/2");
    issue(32'h0, 32'd7, 32'h0, 13'h1FFE, 1'b1, 1'b1, 1'b0, "R2 R5 7/imm -2");
    issue(32'h0, 32'h8000_0000, 32'd1, 13'h0, 1'b0, 1'b1, 1'b0, "R6 positive clamp");
    issue(32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 13'h0, 1'b0, 1'b1, 1'b0, "R5 exact -2^31");
    issue(32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd1, 13'h0, 1'b0, 1'b1, 1'b0, "R7 negative clamp");
    issue(32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 13'h0, 1'b0, 1'b1, 1'b0, "R6 -2^63/-1");
    issue(32'h0, 32'd40, 32'hFFFF_FFF8, 13'h0, 1'b0, 1'b1, 1'b0, "R5 40/-8");
    issue(32'h0, 32'd77, 32'h0, 13'h0, 1'b0, 1'b0, 1'b0, "R8 zero register divisor");
    issue(32'h1234, 32'd77, 32'd9, 13'h0, 1'b1, 1'b1, 1'b0, "R8 zero immediate");
    issue(32'h0, 32'd1000, 32'd10, 13'h0, 1'b0, 1'b0, 1'b1, "R11 poke unsigned");
    issue(32'hFFFF_FFFF, 32'hFFFF_FC18, 32'd10, 13'h0, 1'b0, 1'b1, 1'b1, "R11 poke signed");

    lcg = 32'h1357_9BDF;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] ry, ra, rb;
      lcg = lcg * 32'd1664525 + 32'd1013904223; ry = lcg >> (i % 24);
      lcg = lcg * 32'd1664525 + 32'd1013904223; ra = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223; rb = lcg;
      issue(ry, ra, rb, rb[12:0], rb[31], i[0], 1'b0, i[0] ? "R5 sweep" : "R3 sweep");
    end

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R11 pending items", 64'(sb_q.size()), 64'd0);
    finish_run();
  end
endmodule